// File: doc/BRIEF.md
# Four-Stream Radix-4 Delay-Commutator Stage Scheduler

This block is the data-ordering front end of one radix-4 pipeline stage, shared by four independent sample streams. Each of four input lanes carries one stream, one complex sample per accepted cycle. Each stream advances through symbols of N samples. For every stream the block buffers samples in tapped delay lines. A rotating selector then hands one shared radix-4 butterfly, on every accepted cycle, the four samples x[b], x[b+N/4], x[b+N/2] and x[b+3N/4] of one stream's symbol.

Each stream gets its own extra lag of a whole number of quarter-spans. Because of this, the four streams reach their ready windows in successive quarters of the symbol. The selector moves to the next stream every N/4 accepted cycles. After a short warm-up, the shared butterfly and its three twiddle multipliers receive a full group on every accepted cycle, with no idle slots. Each output group carries a stream tag and the butterfly index b, from which a downstream twiddle generator forms the k, 2k and 3k exponents. The same control works unchanged in every stage of the pipeline.

Top module: `mdc4s_stage_sched`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, out_valid is 0. Reset also restarts the sample position and the warm-up count. A run that follows a reset therefore behaves exactly like the first run.
- R2: out_valid stays 0 for the first 3·N/4 accepted input cycles after reset. It first becomes 1 in the cycle after the input with accepted count 3·N/4 (0-based) is taken.
- R3: Let p be the accepted count modulo N of the input taken at an edge, and q = p div (N/4). The group presented after that edge has out_stream = (q+1) mod 4. Stream s is the one that enters on lane s of in_data, with lane s at bits [SW·s +: SW].
- R4: In the same group, out_bfly = p mod (N/4). Over consecutive valid groups the index therefore steps by one and wraps from N/4−1 to 0. The stream tag changes exactly when the index wraps.
- R5: Output lane k (k = 0..3, bits [SW·k +: SW] of out_data) carries the sample of stream s = out_stream that was accepted (s+3−k)·N/4 accepted cycles before the input that produced the group. The group appears one clock after that input is accepted.
- R6: All four lanes of a valid group come from the same stream. Their symbol indices are spaced exactly N/4 apart, in rising order from lane 0 to lane 3.
- R7: When in_valid is 0, nothing is accepted and the position does not advance. In the next cycle out_valid is 0, and out_data, out_stream and out_bfly keep their previous values.
- R8: Once warm-up is complete, every accepted input cycle yields one valid group in the following cycle. The butterfly is fed on every cycle of continuous input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously by the surrounding logic |
| in_valid | input | 1 | All four lanes carry a new sample this cycle |
| in_data | input | 4·SW | One sample per stream; lane s at bits [SW·s +: SW] |
| out_valid | output | 1 | out_data holds a complete butterfly group |
| out_stream | output | 2 | Stream the current group belongs to |
| out_bfly | output | log2(N)−2 | Butterfly index b within the stage |
| out_data | output | 4·SW | Group samples; lane k holds symbol index b + k·N/4 |

## Verification
The bound checker checks four things on every cycle. out_valid never rises before 3·N/4 samples have been accepted, and it follows every accepted input once warm-up is over. A stall holds all outputs. The butterfly index steps by one between consecutive groups, and the stream tag moves on only when the index wraps. Which stored sample lands on which output lane depends on data values, so only the bench scenarios can show it. These are tagged ramps, random data under random stalls, and a reset in the middle of a run, all compared against a per-stream history of accepted samples.

// File: rtl/mdc4s_pkg.sv
package mdc4s_pkg;
  localparam int unsigned LANES = 4;

  typedef logic [1:0] strm_id_t;

  // stream served in a given quarter of the symbol position
  function automatic strm_id_t quarter_owner(input logic [1:0] quarter);
    return strm_id_t'(quarter + 2'd1);
  endfunction
endpackage

// File: rtl/mdc4s_tap_line.sv
module mdc4s_tap_line #(
  parameter int SW  = 16,
  parameter int Q   = 16,
  parameter int LAG = 0
) (
  input  logic                            clk,
  input  logic                            en,
  input  logic [SW-1:0]                   din,
  output logic [mdc4s_pkg::LANES-1:0][SW-1:0] taps
);
  localparam int DEPTH = (LAG + 3) * Q;

  logic [SW-1:0] sr [DEPTH];

  // data shift chain: no reset, advances only on accepted cycles
  always_ff @(posedge clk) begin
    if (en) begin
      sr[0] <= din;
      for (int i = 1; i < DEPTH; i++) begin
        sr[i] <= sr[i-1];
      end
    end
  end

  // lane k sees the sample (LAG+3-k) quarter-spans older than din
  for (genvar k = 0; k < mdc4s_pkg::LANES; k++) begin : g_tap
    localparam int DLY = (LAG + 3 - k) * Q;
    if (DLY == 0) begin : g_direct
      assign taps[k] = din;
    end else begin : g_stored
      assign taps[k] = sr[DLY-1];
    end
  end
endmodule

// File: rtl/mdc4s_ctrl.sv
module mdc4s_ctrl #(
  parameter int N = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output mdc4s_pkg::strm_id_t       sel,
  output logic [$clog2(N)-3:0]      bfly,
  output logic                      ready
);
  localparam int LN       = $clog2(N);
  localparam int QW       = LN - 2;
  localparam int Q        = N / 4;
  localparam int FILL_MAX = 3 * Q;
  localparam int FW       = $clog2(FILL_MAX + 1);

  logic [LN-1:0] pos_q, pos_d;
  logic [FW-1:0] fill_q, fill_d;

  always_comb begin
    pos_d  = pos_q;
    fill_d = fill_q;
    if (in_valid) begin
      pos_d = LN'(pos_q + 1'b1);
      if (fill_q != FW'(FILL_MAX)) begin
        fill_d = FW'(fill_q + 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      fill_q <= '0;
    end else begin
      pos_q  <= pos_d;
      fill_q <= fill_d;
    end
  end

  assign sel   = mdc4s_pkg::quarter_owner(pos_q[LN-1:LN-2]);
  assign bfly  = pos_q[QW-1:0];
  assign ready = (fill_q == FW'(FILL_MAX));
endmodule

// File: rtl/mdc4s_xbar.sv
module mdc4s_xbar #(
  parameter int SW = 16
) (
  input  logic [mdc4s_pkg::LANES-1:0][mdc4s_pkg::LANES-1:0][SW-1:0] grp_in,
  input  mdc4s_pkg::strm_id_t                                       sel,
  output logic [mdc4s_pkg::LANES-1:0][SW-1:0]                       lane_out
);
  for (genvar k = 0; k < mdc4s_pkg::LANES; k++) begin : g_lane
    always_comb begin
      lane_out[k] = grp_in[sel][k];
    end
  end
endmodule

// File: rtl/mdc4s_stage_sched.sv
module mdc4s_stage_sched #(
  parameter  int N  = 64,
  parameter  int SW = 16,
  localparam int QW = $clog2(N) - 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [3:0][SW-1:0]  in_data,
  output logic                out_valid,
  output logic [1:0]          out_stream,
  output logic [QW-1:0]       out_bfly,
  output logic [3:0][SW-1:0]  out_data
);
  import mdc4s_pkg::*;

  localparam int Q = N / 4;

  strm_id_t                       sel;
  logic [QW-1:0]                  bfly;
  logic                           ready;
  logic [LANES-1:0][LANES-1:0][SW-1:0] grp;
  logic [LANES-1:0][SW-1:0]       lanes;

  logic                           valid_d;
  logic [1:0]                     stream_d;
  logic [QW-1:0]                  bfly_d;
  logic [LANES-1:0][SW-1:0]       data_d;

  mdc4s_ctrl #(.N(N)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .sel      (sel),
    .bfly     (bfly),
    .ready    (ready)
  );

  for (genvar s = 0; s < LANES; s++) begin : g_stream
    mdc4s_tap_line #(.SW(SW), .Q(Q), .LAG(s)) u_line (
      .clk  (clk),
      .en   (in_valid),
      .din  (in_data[s]),
      .taps (grp[s])
    );
  end

  mdc4s_xbar #(.SW(SW)) u_xbar (
    .grp_in   (grp),
    .sel      (sel),
    .lane_out (lanes)
  );

  always_comb begin
    valid_d  = in_valid & ready;
    stream_d = out_stream;
    bfly_d   = out_bfly;
    data_d   = out_data;
    if (in_valid) begin
      stream_d = sel;
      bfly_d   = bfly;
      data_d   = lanes;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_stream <= '0;
      out_bfly   <= '0;
      out_data   <= '0;
    end else begin
      out_valid  <= valid_d;
      out_stream <= stream_d;
      out_bfly   <= bfly_d;
      out_data   <= data_d;
    end
  end
endmodule

// File: rtl/mdc4s_stage_sched_chk.sv
module mdc4s_stage_sched_chk #(
  parameter  int N  = 64,
  parameter  int SW = 16,
  localparam int QW = $clog2(N) - 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               out_valid,
  input logic [1:0]         out_stream,
  input logic [QW-1:0]      out_bfly,
  input logic [3:0][SW-1:0] out_data
);
  localparam int Q   = N / 4;
  localparam int LIM = 3 * Q + 1;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= '0;
    end else if (in_valid && seen != CW'(LIM)) begin
      seen <= CW'(seen + 1'b1);
    end
  end

  // R2: no group before the warm-up count has been accepted
  a_r2_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (seen > CW'(3 * Q)));

  // R8: after warm-up every accepted input yields a group
  a_r8_valid_continuous: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid) && seen > CW'(3 * Q)) |-> out_valid);

  // R7: a stall holds all outputs and drops valid
  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> (!out_valid && $stable(out_data) &&
                          $stable(out_stream) && $stable(out_bfly)));

  // R4: butterfly index steps by one between consecutive groups
  a_r4_bfly_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> (out_bfly == QW'($past(out_bfly) + 1'b1)));

  // R3: stream tag advances only where the index wraps
  a_r3_stream_turns: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |->
      ((out_bfly == '0) ? (out_stream == 2'($past(out_stream) + 2'd1))
                        : (out_stream == $past(out_stream))));
endmodule

bind mdc4s_stage_sched mdc4s_stage_sched_chk #(.N(N), .SW(SW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .out_stream (out_stream),
  .out_bfly   (out_bfly),
  .out_data   (out_data)
);

// File: tb/mdc4s_stage_sched_test.sv
`timescale 1ns/1ps
module mdc4s_stage_sched_test;
  localparam int N    = 64;
  localparam int SW   = 16;
  localparam int Q    = N / 4;
  localparam int QW   = $clog2(N) - 2;
  localparam int HIST = 256;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               in_valid;
  logic [3:0][SW-1:0] in_data;
  logic               out_valid;
  logic [1:0]         out_stream;
  logic [QW-1:0]      out_bfly;
  logic [3:0][SW-1:0] out_data;

  logic [SW-1:0] hist [4][HIST];
  logic [3:0][SW-1:0] last_data;
  logic [1:0]    last_stream;
  logic [QW-1:0] last_bfly;
  int  acc;
  int  checks = 0;
  int  fails  = 0;
  bit  after_rst = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  mdc4s_stage_sched #(.N(N), .SW(SW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_stream(out_stream), .out_bfly(out_bfly),
    .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_stream(input int a);
    return (((a % N) / Q) + 1) % 4;
  endfunction

  function automatic int exp_bfly(input int a);
    return (a % N) % Q;
  endfunction

  // ramp=1: tagged ramp {stream, count}; ramp=0: random data
  task automatic step(input bit v, input bit ramp);
    @(negedge clk);
    in_valid = v;
    for (int s = 0; s < 4; s++) begin
      logic [SW-1:0] val;
      val = ramp ? {2'(s), 14'(acc)} : SW'($urandom);
      in_data[s] = val;
      if (v) hist[s][acc % HIST] = val;
    end
    @(posedge clk);
    #1;
    if (v) begin
      bit ev;
      ev = (acc >= 3 * Q);
      chk(out_valid == ev, after_rst ? "R1" : (ev ? "R8" : "R2"), int'(out_valid), int'(ev));
      if (ev && out_valid) begin
        int s, b;
        s = exp_stream(acc);
        b = exp_bfly(acc);
        chk(int'(out_stream) == s, "R3", int'(out_stream), s);
        chk(int'(out_bfly) == b, "R4", int'(out_bfly), b);
        for (int k = 0; k < 4; k++) begin
          int idx;
          idx = acc - (s + 3 - k) * Q;
          chk(out_data[k] == hist[s][idx % HIST], "R5", int'(out_data[k]), int'(hist[s][idx % HIST]));
          if (ramp) begin
            int base;
            base = int'(out_data[0][13:0]);
            chk(int'(out_data[k][15:14]) == int'(out_stream), "R6", int'(out_data[k][15:14]), int'(out_stream));
            chk(int'(out_data[k][13:0]) == base + k * Q, "R6", int'(out_data[k][13:0]), base + k * Q);
          end
        end
      end
      acc++;
    end else begin
      chk(out_valid == 1'b0, "R7", int'(out_valid), 0);
      chk(out_data == last_data, "R7", int'(out_data[0]), int'(last_data[0]));
      chk(out_stream == last_stream && out_bfly == last_bfly, "R7", int'(out_bfly), int'(last_bfly));
    end
    last_data   = out_data;
    last_stream = out_stream;
    last_bfly   = out_bfly;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    chk(out_stream == 2'd0 && out_bfly == '0, "R1", int'(out_bfly), 0);
    @(negedge clk);
    rst_n = 1'b1;
    acc = 0;
    last_data   = out_data;
    last_stream = out_stream;
    last_bfly   = out_bfly;
  endtask

  initial begin
    void'($urandom(32'h5EED));
    in_valid = 1'b0;
    in_data  = '0;
    acc      = 0;
    rst_n    = 1'b0;
    do_reset();

    // continuous tagged ramps: warm-up and full occupancy
    for (int i = 0; i < 4 * N; i++) step(1'b1, 1'b1);

    // tagged ramps with random stalls
    for (int i = 0; i < 4 * N; i++) step(($urandom % 4) != 0, 1'b1);

    // directed stall run of several cycles
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1);

    // random data with random stalls
    for (int i = 0; i < 10 * N; i++) step(($urandom % 5) != 0, 1'b0);

    // reset in the middle of a run, then restart
    do_reset();
    after_rst = 1;
    for (int i = 0; i < 3 * Q + 2; i++) step(1'b1, 1'b1);
    after_rst = 0;
    for (int i = 0; i < 2 * N; i++) step(1'b1, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R8: watchdog expired actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule